// File: doc/BRIEF.md
# Unaligned AXI4 Write Burst Generator

This block converts an internal write request (start byte address, byte count, transaction ID and optional first/last DWord byte enables) into AXI4 write bursts on a 256-bit data bus. It drives the write-address and write-data channels and absorbs write responses. The request may begin and end on any byte lane. The block works out the burst length and builds a byte-exact strobe for each beat. Payload arrives on a valid/ready stream that is already placed on the correct byte lanes, and each accepted beat is forwarded as one W beat.

A request whose span exceeds the burst limit is cut into consecutive bursts. All of them carry the request's ID, so the target receives them in order. The first burst starts at the request address. Each later burst starts at the beat-aligned address that follows the last beat of the burst before it. A new request is taken only after every address and data phase of the current one has completed. Outstanding write responses are counted, and the block reports idle only when none remain.

Top module: `axwm_write_master`

## Requirements
- R1: After reset, m_awvalid and m_wvalid are low, req_ready is high and idle is high.
- R2: While m_awvalid is high and m_awready is low, m_awvalid stays high and m_awaddr, m_awlen and m_awid do not change.
- R3: While m_wvalid is high and m_wready is low, m_wvalid stays high and m_wdata, m_wstrb and m_wlast do not change.
- R4: m_awsize is 5 and m_awburst is 1 (incrementing). m_awlen is one less than the number of 32-byte beats the burst covers. Each burst carries exactly m_awlen+1 W beats, and m_wlast is high only on the last of them.
- R5: Bit i of m_wstrb is set exactly when byte lane i of that beat lies inside [address, address+bytes). Only the first and last beats of a request may be partial. Examples: address 0x5 with 2 bytes gives one beat with strobe 0x00000060. Address 0x12 with 16 bytes gives m_awlen 1 and strobes 0xFFFC0000 then 0x00000003.
- R6: With req_be_en high, req_bytes = 4 and a DWord-aligned address, the single beat's strobe is req_first_be (bit k is byte k of that DWord) placed on the DWord's lanes. Non-contiguous patterns pass through unchanged.
- R7: With req_be_en high, req_bytes = 8 and an address that is a multiple of 8, req_first_be covers the lower DWord and req_last_be the upper DWord. In every other case req_be_en has no effect and the strobe follows R5.
- R8: A request spanning more than MAX_BEATS beats (default 16) is issued as consecutive bursts of MAX_BEATS beats, with the remainder in the final burst. All of them carry the same m_awid. Each follow-on burst starts at the previous burst's beat-aligned address plus 32 × its beat count.
- R9: req_ready is low, and no new request is accepted, from acceptance until the last address and data handshakes of the request.
- R10: m_bready is always high. idle is high only when no request is in progress and no write response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Start byte address |
| req_bytes | input | 13 | Byte count, 1 or more |
| req_id | input | 4 | Transaction ID for all bursts |
| req_be_en | input | 1 | Use explicit DWord byte enables |
| req_first_be | input | 4 | First DWord byte enables |
| req_last_be | input | 4 | Second DWord byte enables |
| wd_valid | input | 1 | Payload beat present |
| wd_ready | output | 1 | Payload beat taken |
| wd_data | input | 256 | Lane-aligned payload beat |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code (5) |
| m_awburst | output | 2 | Burst type (incrementing) |
| m_awid | output | 4 | Burst ID |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 256 | Write data |
| m_wstrb | output | 32 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| idle | output | 1 | No work and no outstanding response |

## Verification
A wrong remaining-byte count or beat pointer shows up at once on m_wstrb of the next beat, as a partial middle beat or a wrong tail mask. It also shows up by the end of the burst, when m_wlast falls on the wrong beat. A corrupted burst plan shows up on the next m_awlen or m_awaddr, one cycle after the previous burst closes. An error in response counting is visible only through idle, after the last response returns. Because of this, the bench holds responses back and checks idle on both sides of their release.

// File: rtl/axwm_pkg.sv
package axwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_BURST = 2'd2
    } axwm_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/axwm_burst_plan.sv
module axwm_burst_plan #(
    parameter int LANE_W    = 5,
    parameter int BYTES_W   = 13,
    parameter int MAX_BEATS = 16
) (
    input  logic [LANE_W-1:0]  lo,
    input  logic [BYTES_W-1:0] bytes_left,
    output logic [7:0]         len
);
    localparam int STRB_W = 1 << LANE_W;
    localparam int TW     = BYTES_W + 2;

    logic [TW-1:0] span;
    logic [TW-1:0] total;
    logic [TW-1:0] take;

    always_comb begin
        span  = TW'(lo) + TW'(bytes_left) + TW'(STRB_W - 1);
        total = span >> LANE_W;
        take  = (total > TW'(MAX_BEATS)) ? TW'(MAX_BEATS) : total;
        len   = 8'(take - TW'(1));
    end
endmodule

// File: rtl/axwm_strobe_gen.sv
module axwm_strobe_gen #(
    parameter int LANE_W  = 5,
    parameter int BYTES_W = 13
) (
    input  logic [LANE_W-1:0]     lo,
    input  logic [BYTES_W-1:0]    bytes_left,
    input  logic                  be_en,
    input  logic                  two_dw,
    input  logic [3:0]            first_be,
    input  logic [3:0]            last_be,
    output logic [(1<<LANE_W)-1:0] strb,
    output logic [BYTES_W-1:0]    consumed
);
    localparam int STRB_W = 1 << LANE_W;
    localparam int XW     = BYTES_W + 2;
    localparam int DW_W   = LANE_W - 2;

    logic [XW-1:0]     end_x;
    logic [XW-1:0]     room;
    logic [STRB_W-1:0] span_mask;
    logic [STRB_W-1:0] be_mask;
    logic [DW_W-1:0]   dw_idx;

    always_comb begin
        end_x = XW'(lo) + XW'(bytes_left);
        for (int i = 0; i < STRB_W; i++) begin
            span_mask[i] = (XW'(i) >= XW'(lo)) && (XW'(i) < end_x);
        end

        dw_idx  = lo[LANE_W-1:2];
        be_mask = STRB_W'(first_be) << {dw_idx, 2'b00};
        if (two_dw) begin
            be_mask = be_mask | (STRB_W'(last_be) << {dw_idx, 2'b00} << 4);
        end

        strb = be_en ? be_mask : span_mask;

        room     = XW'(STRB_W) - XW'(lo);
        consumed = (XW'(bytes_left) < room) ? bytes_left : BYTES_W'(room);
    end
endmodule

// File: rtl/axwm_bresp_track.sv
module axwm_bresp_track #(
    parameter int OUT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aw_fire,
    input  logic b_fire,
    output logic full,
    output logic empty
);
    logic [OUT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case ({aw_fire, b_fire})
            2'b10:   cnt_d = cnt_q + OUT_W'(1);
            2'b01:   cnt_d = cnt_q - OUT_W'(1);
            default: cnt_d = cnt_q;
        endcase
        full  = (cnt_q == {OUT_W{1'b1}});
        empty = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/axwm_write_master.sv
module axwm_write_master #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 256,
    parameter int ID_W      = 4,
    parameter int BYTES_W   = 13,
    parameter int MAX_BEATS = 16,
    parameter int OUT_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BYTES_W-1:0]  req_bytes,
    input  logic [ID_W-1:0]     req_id,
    input  logic                req_be_en,
    input  logic [3:0]          req_first_be,
    input  logic [3:0]          req_last_be,
    input  logic                wd_valid,
    output logic                wd_ready,
    input  logic [DATA_W-1:0]   wd_data,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic [ID_W-1:0]     m_awid,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic                idle
);
    import axwm_pkg::*;

    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = $clog2(STRB_W);
    localparam int BEAT_W = $clog2(MAX_BEATS + 1);

    typedef struct packed {
        axwm_state_e        st;
        logic [ADDR_W-1:0]  addr;
        logic [BYTES_W-1:0] bytes_left;
        logic [ID_W-1:0]    id;
        logic               be_en;
        logic               two_dw;
        logic [3:0]         first_be;
        logic [3:0]         last_be;
        logic               aw_pend;
        logic [ADDR_W-1:0]  awaddr;
        logic [7:0]         awlen;
        logic [BEAT_W-1:0]  w_left;
    } axwm_regs_t;

    axwm_regs_t r_d, r_q;

    logic [7:0]         plan_len;
    logic [STRB_W-1:0]  beat_strb;
    logic [BYTES_W-1:0] beat_bytes;
    logic               out_full;
    logic               out_empty;
    logic               aw_fire;
    logic               w_fire;
    logic               be_ok;

    axwm_burst_plan #(
        .LANE_W    (LANE_W),
        .BYTES_W   (BYTES_W),
        .MAX_BEATS (MAX_BEATS)
    ) u_plan (
        .lo         (r_q.addr[LANE_W-1:0]),
        .bytes_left (r_q.bytes_left),
        .len        (plan_len)
    );

    axwm_strobe_gen #(
        .LANE_W  (LANE_W),
        .BYTES_W (BYTES_W)
    ) u_strb (
        .lo         (r_q.addr[LANE_W-1:0]),
        .bytes_left (r_q.bytes_left),
        .be_en      (r_q.be_en),
        .two_dw     (r_q.two_dw),
        .first_be   (r_q.first_be),
        .last_be    (r_q.last_be),
        .strb       (beat_strb),
        .consumed   (beat_bytes)
    );

    axwm_bresp_track #(
        .OUT_W (OUT_W)
    ) u_btrk (
        .clk     (clk),
        .rst_n   (rst_n),
        .aw_fire (aw_fire),
        .b_fire  (m_bvalid),
        .full    (out_full),
        .empty   (out_empty)
    );

    always_comb begin
        r_d = r_q;

        m_awvalid = r_q.aw_pend && !out_full;
        m_awaddr  = r_q.awaddr;
        m_awlen   = r_q.awlen;
        m_awsize  = 3'(LANE_W);
        m_awburst = BURST_INCR;
        m_awid    = r_q.id;

        m_wvalid  = (r_q.st == ST_BURST) && (r_q.w_left != '0) && wd_valid;
        wd_ready  = (r_q.st == ST_BURST) && (r_q.w_left != '0) && m_wready;
        m_wdata   = wd_data;
        m_wstrb   = beat_strb;
        m_wlast   = (r_q.w_left == BEAT_W'(1));

        m_bready  = 1'b1;
        req_ready = (r_q.st == ST_IDLE);
        idle      = (r_q.st == ST_IDLE) && out_empty;

        aw_fire = m_awvalid && m_awready;
        w_fire  = m_wvalid && m_wready;

        be_ok = req_be_en &&
                (((req_bytes == BYTES_W'(4)) && (req_addr[1:0] == 2'b00)) ||
                 ((req_bytes == BYTES_W'(8)) && (req_addr[2:0] == 3'b000)));

        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr       = req_addr;
                    r_d.bytes_left = req_bytes;
                    r_d.id         = req_id;
                    r_d.be_en      = be_ok;
                    r_d.two_dw     = (req_bytes == BYTES_W'(8));
                    r_d.first_be   = req_first_be;
                    r_d.last_be    = req_last_be;
                    r_d.st         = ST_PLAN;
                end
            end
            ST_PLAN: begin
                r_d.awaddr  = r_q.addr;
                r_d.awlen   = plan_len;
                r_d.w_left  = BEAT_W'(plan_len) + BEAT_W'(1);
                r_d.aw_pend = 1'b1;
                r_d.st      = ST_BURST;
            end
            ST_BURST: begin
                if (aw_fire) begin
                    r_d.aw_pend = 1'b0;
                end
                if (w_fire) begin
                    r_d.addr = {r_q.addr[ADDR_W-1:LANE_W] + (ADDR_W-LANE_W)'(1),
                                {LANE_W{1'b0}}};
                    r_d.bytes_left = r_q.bytes_left - beat_bytes;
                    r_d.w_left     = r_q.w_left - BEAT_W'(1);
                end
                if (!r_d.aw_pend && (r_d.w_left == '0)) begin
                    r_d.st = (r_d.bytes_left == '0) ? ST_IDLE : ST_PLAN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/axwm_write_master_chk.sv
module axwm_write_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 256,
    parameter int ID_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                m_awvalid,
    input logic                m_awready,
    input logic [ADDR_W-1:0]   m_awaddr,
    input logic [7:0]          m_awlen,
    input logic [ID_W-1:0]     m_awid,
    input logic                m_wvalid,
    input logic                m_wready,
    input logic [DATA_W-1:0]   m_wdata,
    input logic [DATA_W/8-1:0] m_wstrb,
    input logic                m_wlast,
    input logic                m_bready,
    input logic                idle
);
    logic [7:0] beat_cnt;
    logic       w_hs;

    assign w_hs = m_wvalid && m_wready;

    always_ff @(posedge clk) begin
        if (!rst_n)                beat_cnt <= '0;
        else if (w_hs && m_wlast)  beat_cnt <= '0;
        else if (w_hs)             beat_cnt <= beat_cnt + 8'd1;
    end

    a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=>
            (m_awvalid && $stable(m_awaddr) && $stable(m_awlen) && $stable(m_awid)));

    a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=>
            (m_wvalid && $stable(m_wdata) && $stable(m_wstrb) && $stable(m_wlast)));

    a_r4_last_on_count: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hs && m_wlast) |-> (beat_cnt == m_awlen));

    a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hs && !m_wlast) |-> (beat_cnt < m_awlen));

    a_r5_middle_full: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && (beat_cnt != 8'd0) && !m_wlast) |-> (&m_wstrb));

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!m_awvalid && !m_wvalid));

    a_r10_bready: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready);

    a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> req_ready);
endmodule

bind axwm_write_master axwm_write_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awaddr  (m_awaddr),
    .m_awlen   (m_awlen),
    .m_awid    (m_awid),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wdata   (m_wdata),
    .m_wstrb   (m_wstrb),
    .m_wlast   (m_wlast),
    .m_bready  (m_bready),
    .idle      (idle)
);

// File: tb/axwm_write_master_tb_top.sv
module axwm_write_master_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic [12:0]  req_bytes;
    logic [3:0]   req_id;
    logic         req_be_en;
    logic [3:0]   req_first_be;
    logic [3:0]   req_last_be;
    logic         wd_valid;
    logic         wd_ready;
    logic [255:0] wd_data;
    logic         m_awvalid;
    logic         m_awready;
    logic [31:0]  m_awaddr;
    logic [7:0]   m_awlen;
    logic [2:0]   m_awsize;
    logic [1:0]   m_awburst;
    logic [3:0]   m_awid;
    logic         m_wvalid;
    logic         m_wready;
    logic [255:0] m_wdata;
    logic [31:0]  m_wstrb;
    logic         m_wlast;
    logic         m_bvalid;
    logic         m_bready;
    logic         idle;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    axwm_write_master dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_id(req_id), .req_be_en(req_be_en),
        .req_first_be(req_first_be), .req_last_be(req_last_be),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_awid(m_awid), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .idle(idle)
    );

    // logs of handshakes
    logic [31:0] aw_addr_l [256];
    logic [7:0]  aw_len_l  [256];
    logic [3:0]  aw_id_l   [256];
    logic [2:0]  aw_size_l [256];
    logic [1:0]  aw_brst_l [256];
    logic [31:0] w_strb_l  [256];
    logic        w_last_l  [256];
    logic [31:0] w_data_l  [256];
    int aw_n = 0;
    int w_n  = 0;
    int beat_no = 0;
    int pend_b = 0;
    int cyc = 0;
    logic hold_b = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_strb(input int a, input int n, input int j);
        logic [31:0] s;
        int base;
        s = '0;
        base = (a / 32) * 32 + 32 * j;
        for (int i = 0; i < 32; i++) begin
            if ((base + i >= a) && (base + i < a + n)) s[i] = 1'b1;
        end
        return s;
    endfunction

    // slave model and payload source
    initial begin
        bit aw_f, w_f, b_f;
        m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0;
        wd_valid = 1'b0; wd_data = '0;
        forever begin
            @(negedge clk);
            aw_f = rst_n && m_awvalid && m_awready;
            w_f  = rst_n && m_wvalid && m_wready;
            b_f  = rst_n && m_bvalid && m_bready;
            if (aw_f) begin
                aw_addr_l[aw_n] = m_awaddr; aw_len_l[aw_n] = m_awlen;
                aw_id_l[aw_n] = m_awid; aw_size_l[aw_n] = m_awsize;
                aw_brst_l[aw_n] = m_awburst; aw_n++;
            end
            if (w_f) begin
                w_strb_l[w_n] = m_wstrb; w_last_l[w_n] = m_wlast;
                w_data_l[w_n] = m_wdata[31:0]; w_n++;
            end
            @(posedge clk); #1;
            cyc++;
            if (w_f) beat_no++;
            pend_b = pend_b + (aw_f ? 1 : 0) - (b_f ? 1 : 0);
            m_awready = (cyc % 3) != 2;
            m_wready  = (cyc % 5) != 3;
            wd_valid  = rst_n;
            wd_data   = {8{32'(beat_no)}};
            m_bvalid  = (pend_b > 0) && !hold_b;
        end
    end

    task automatic run_req(input int a, input int n, input logic [3:0] id,
                           input logic be, input logic [3:0] fbe, input logic [3:0] lbe,
                           input bit wait_idle);
        int guard;
        @(posedge clk); #1;
        req_addr = 32'(a); req_bytes = 13'(n); req_id = id;
        req_be_en = be; req_first_be = fbe; req_last_be = lbe;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R9 busy after accept", 64'(req_ready), 64'd0);
        guard = 0;
        while (!req_ready && guard < 4000) begin @(negedge clk); guard++; end
        check(guard < 4000, "R9 request completes", 64'(guard), 64'd0);
        if (wait_idle) begin
            guard = 0;
            while (!idle && guard < 200) begin @(negedge clk); guard++; end
            check(idle == 1'b1, "R10 idle after responses", 64'(idle), 64'd1);
        end
    endtask

    // generic checker of a contiguous request against R4, R5, R8
    task automatic verify_span(input int a, input int n, input logic [3:0] id,
                               input int aw0, input int w0, input int d0);
        int total, nb, k, j, bb;
        total = ((a % 32) + n + 31) / 32;
        nb = (total + 15) / 16;
        check(aw_n - aw0 == nb, "R8 burst count", 64'(aw_n - aw0), 64'(nb));
        check(w_n - w0 == total, "R4 beat count", 64'(w_n - w0), 64'(total));
        j = 0;
        for (k = 0; k < nb && k < aw_n - aw0; k++) begin
            bb = (total - 16 * k > 16) ? 16 : total - 16 * k;
            check(aw_len_l[aw0+k] == 8'(bb - 1), "R4 awlen", 64'(aw_len_l[aw0+k]), 64'(bb - 1));
            check(aw_size_l[aw0+k] == 3'd5 && aw_brst_l[aw0+k] == 2'd1, "R4 size/burst",
                  64'({aw_size_l[aw0+k], aw_brst_l[aw0+k]}), 64'h15);
            check(aw_id_l[aw0+k] == id, "R8 same id", 64'(aw_id_l[aw0+k]), 64'(id));
            check(aw_addr_l[aw0+k] == ((k == 0) ? 32'(a) : 32'((a / 32) * 32 + 512 * k)),
                  "R8 burst address", 64'(aw_addr_l[aw0+k]),
                  64'((k == 0) ? a : (a / 32) * 32 + 512 * k));
            for (int b = 0; b < bb && j < w_n - w0; b++) begin
                check(w_strb_l[w0+j] == exp_strb(a, n, j), "R5 strobe",
                      64'(w_strb_l[w0+j]), 64'(exp_strb(a, n, j)));
                check(w_last_l[w0+j] == (b == bb - 1), "R4 wlast",
                      64'(w_last_l[w0+j]), 64'(b == bb - 1));
                check(w_data_l[w0+j] == 32'(d0 + j), "R4 data order",
                      64'(w_data_l[w0+j]), 64'(d0 + j));
                j++;
            end
        end
    endtask

    task automatic t_reset;
        check(m_awvalid == 1'b0, "R1 awvalid low", 64'(m_awvalid), 64'd0);
        check(m_wvalid == 1'b0, "R1 wvalid low", 64'(m_wvalid), 64'd0);
        check(req_ready == 1'b1, "R1 req_ready high", 64'(req_ready), 64'd1);
        check(idle == 1'b1, "R1 idle high", 64'(idle), 64'd1);
    endtask

    task automatic t_small;
        int aw0 = aw_n, w0 = w_n, d0 = beat_no;
        run_req(5, 2, 4'h3, 1'b0, 4'h0, 4'h0, 1'b1);
        check(w_strb_l[w0] == 32'h0000_0060, "R5 lanes 5,6", 64'(w_strb_l[w0]), 64'h60);
        verify_span(5, 2, 4'h3, aw0, w0, d0);
    endtask

    task automatic t_two_beat;
        int aw0 = aw_n, w0 = w_n, d0 = beat_no;
        run_req(32'h12, 16, 4'h5, 1'b0, 4'h0, 4'h0, 1'b1);
        check(aw_len_l[aw0] == 8'd1, "R4 awlen 1", 64'(aw_len_l[aw0]), 64'd1);
        check(w_strb_l[w0] == 32'hFFFC_0000, "R5 first beat", 64'(w_strb_l[w0]), 64'hFFFC0000);
        check(w_strb_l[w0+1] == 32'h0000_0003, "R5 last beat", 64'(w_strb_l[w0+1]), 64'h3);
        verify_span(32'h12, 16, 4'h5, aw0, w0, d0);
    endtask

    task automatic t_split;
        int aw0 = aw_n, w0 = w_n, d0 = beat_no;
        run_req(32'h43, 1280, 4'h9, 1'b0, 4'h0, 4'h0, 1'b1);
        check(aw_n - aw0 == 3, "R8 three bursts", 64'(aw_n - aw0), 64'd3);
        check(aw_len_l[aw0+2] == 8'd8, "R8 tail length", 64'(aw_len_l[aw0+2]), 64'd8);
        check(w_strb_l[w0+40] == 32'h7, "R5 tail strobe", 64'(w_strb_l[w0+40]), 64'h7);
        verify_span(32'h43, 1280, 4'h9, aw0, w0, d0);
    endtask

    task automatic t_be_one;
        int w0 = w_n;
        run_req(32'h24, 4, 4'h1, 1'b1, 4'b1010, 4'b0000, 1'b1);
        check(w_n - w0 == 1, "R6 one beat", 64'(w_n - w0), 64'd1);
        check(w_strb_l[w0] == 32'h0000_00A0, "R6 sparse dword", 64'(w_strb_l[w0]), 64'hA0);
    endtask

    task automatic t_be_two;
        int w0 = w_n;
        run_req(32'h08, 8, 4'h2, 1'b1, 4'b0101, 4'b1001, 1'b1);
        check(w_strb_l[w0] == 32'h0000_9500, "R7 sparse pair", 64'(w_strb_l[w0]), 64'h9500);
    endtask

    task automatic t_be_ignored;
        int aw0 = aw_n, w0 = w_n, d0 = beat_no;
        run_req(32'h0C, 8, 4'h4, 1'b1, 4'b0001, 4'b0001, 1'b1);
        check(w_strb_l[w0] == 32'h000F_F000, "R7 enables ignored", 64'(w_strb_l[w0]), 64'hFF000);
        verify_span(32'h0C, 8, 4'h4, aw0, w0, d0);
    endtask

    task automatic t_bresp_hold;
        hold_b = 1'b1;
        run_req(32'h100, 64, 4'h6, 1'b0, 4'h0, 4'h0, 1'b0);
        repeat (5) @(negedge clk);
        check(idle == 1'b0, "R10 idle low with response pending", 64'(idle), 64'd0);
        check(req_ready == 1'b1, "R9 ready once phases done", 64'(req_ready), 64'd1);
        check(m_bready == 1'b1, "R10 bready high", 64'(m_bready), 64'd1);
        hold_b = 1'b0;
        repeat (6) @(negedge clk);
        check(idle == 1'b1, "R10 idle after release", 64'(idle), 64'd1);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_bytes = '0;
        req_id = '0; req_be_en = 1'b0; req_first_be = '0; req_last_be = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small();
        t_two_beat();
        t_split();
        t_be_one();
        t_be_two();
        t_be_ignored();
        t_bresp_hold();
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule